// File: doc/BRIEF.md
# Message Controller Interrupt Flag Aggregator

This block condenses the per-buffer and per-source status of a bus communication controller into a five-bit summary flag register, which the host can read, and a single interrupt request line. It takes a flag bit and an enable bit for every message buffer, plus a vector that marks each buffer as receive or transmit. It also takes the occupancy of the receive FIFO, a one-cycle FIFO overrun pulse, the lock state of message buffer 0 and the bits of the host-interface error register.

The receive, transmit and error summaries are recomputed from their inputs in every cycle, so they always match the current buffer state. The FIFO not-empty flag is registered and held while buffer 0 stays locked. The overrun flag latches an event and holds it until the host clears it. An enable register chooses which summary flags may raise the interrupt. The interrupt is registered, so it follows the pending sources one clock later.

Top module: `msg_irq_aggregator`

## Requirements
- R1: Summary bit 0 (receive) is 1 in the same cycle whenever some buffer marked receive (`buf_is_tx` bit 0) has both its flag bit and its enable bit at 1, or `fifo_level` is non-zero. Otherwise it is 0.
- R2: Summary bit 1 (transmit) is 1 in the same cycle whenever some buffer marked transmit (`buf_is_tx` bit 1) has both its flag bit and its enable bit at 1. It is 0 when no enabled transmit buffer has its flag set. A transmit buffer that is not enabled has no effect on it.
- R3: Summary bit 2 (error) is the OR of all `chi_err` bits, in the same cycle.
- R4: Summary bit 3 (FIFO not-empty) is 1 after any clock edge at which `fifo_level` was non-zero. It returns to 0 only after an edge at which `fifo_level` was zero and `buf0_locked` was 0. While the FIFO is empty and buffer 0 is locked, the bit keeps its value.
- R5: Summary bit 4 (overrun) becomes 1 after an edge at which `fifo_ovr_pulse` was 1. It stays 1 until an edge at which `host_flag_wr` is 1 with `host_wdata` bit 4 at 1. A pulse arriving in the same cycle as that clear wins, and the flag stays 1.
- R6: A host flag write has no effect on summary bits 0 to 3, whatever data it carries.
- R7: An edge with `host_en_wr` at 1 loads `host_wdata` into the enable register. `irq_en` reads it back after that edge and keeps it until the next enable write. Enable bit positions match the flag bit positions.
- R8: `irq` is 1 after any edge at which some summary bit and its enable bit were both 1. It is 0 one edge after no such pair remains.
- R9: A clock edge with `rst_n` at 0 clears the FIFO not-empty flag, the overrun flag, the enable register and `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| buf_flag | input | NUM_BUF | Per-buffer status flag (receive: full, transmit: empty) |
| buf_ien | input | NUM_BUF | Per-buffer interrupt enable |
| buf_is_tx | input | NUM_BUF | Buffer type, 1 = transmit, 0 = receive |
| fifo_level | input | clog2(FIFO_DEPTH+1) | Receive FIFO occupancy |
| fifo_ovr_pulse | input | 1 | One-cycle FIFO overrun event |
| buf0_locked | input | 1 | Message buffer 0 is locked by the host |
| chi_err | input | ERR_W | Host-interface error register bits |
| host_flag_wr | input | 1 | Host write strobe for the summary flag register |
| host_en_wr | input | 1 | Host write strobe for the enable register |
| host_wdata | input | 5 | Host write data |
| irq_flags | output | 5 | Summary flags: 0 rx, 1 tx, 2 error, 3 FIFO not-empty, 4 overrun |
| irq_en | output | 5 | Enable register contents |
| irq | output | 1 | Combined interrupt request |

## Verification
The receive, transmit and error summaries are due in the same cycle as their stimulus. The bench drives inputs just after a rising edge and checks these summaries at the falling edge of that same cycle. The FIFO not-empty flag, the overrun flag and the enable register are due one edge after their cause, and `irq` one edge after the flag and enable pair it depends on becomes visible. Each expectation goes into the scoreboard tagged with the cycle in which it is due. The monitor compares it only at that cycle's falling edge, so the bench never reads a value while it is still in flight.

// File: rtl/msg_irq_pkg.sv
package msg_irq_pkg;
    localparam int NUM_SRC = 5;
    localparam int SRC_RX  = 0;
    localparam int SRC_TX  = 1;
    localparam int SRC_ERR = 2;
    localparam int SRC_FNE = 3;
    localparam int SRC_OVR = 4;

    typedef logic [NUM_SRC-1:0] src_vec_t;

    typedef struct packed {
        logic fne;
        logic ovr;
    } fifo_state_t;

    typedef struct packed {
        src_vec_t en;
        logic     irq;
    } irq_state_t;
endpackage

// File: rtl/msg_buf_summary.sv
module msg_buf_summary #(
    parameter int NUM_BUF = 16
) (
    input  logic [NUM_BUF-1:0] buf_flag,
    input  logic [NUM_BUF-1:0] buf_ien,
    input  logic [NUM_BUF-1:0] buf_is_tx,
    output logic               rx_any,
    output logic               tx_any
);
    logic [NUM_BUF-1:0] rx_hit;
    logic [NUM_BUF-1:0] tx_hit;

    // Qualify each buffer's flag by its enable and its direction
    for (genvar i = 0; i < NUM_BUF; i++) begin : g_buf
        always_comb begin
            rx_hit[i] = buf_flag[i] & buf_ien[i] & ~buf_is_tx[i];
            tx_hit[i] = buf_flag[i] & buf_ien[i] &  buf_is_tx[i];
        end
    end

    always_comb begin
        rx_any = |rx_hit;
        tx_any = |tx_hit;
    end
endmodule

// File: rtl/msg_fifo_status.sv
module msg_fifo_status
    import msg_irq_pkg::*;
#(
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic             buf0_locked,
    input  logic             ovr_pulse,
    input  logic             ovr_clr,
    output logic             fne,
    output logic             ovr
);
    fifo_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Not-empty: set by occupancy, held while buffer 0 is still locked
        st_d.fne = (fifo_level != '0) | (st_q.fne & buf0_locked);
        // Overrun: a new event takes precedence over a host clear
        st_d.ovr = ovr_pulse | (st_q.ovr & ~ovr_clr);
        if (!rst_n) st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign fne = st_q.fne;
    assign ovr = st_q.ovr;
endmodule

// File: rtl/msg_irq_ctrl.sv
module msg_irq_ctrl
    import msg_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en_wr,
    input  src_vec_t en_wdata,
    input  src_vec_t flags,
    output src_vec_t en,
    output logic     irq
);
    irq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en_wr) st_d.en = en_wdata;
        st_d.irq = |(flags & st_q.en);
        if (!rst_n) st_d = '0;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign en  = st_q.en;
    assign irq = st_q.irq;
endmodule

// File: rtl/msg_irq_aggregator.sv
module msg_irq_aggregator
    import msg_irq_pkg::*;
#(
    parameter int NUM_BUF    = 16,
    parameter int FIFO_DEPTH = 8,
    parameter int ERR_W      = 4,
    localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_BUF-1:0] buf_flag,
    input  logic [NUM_BUF-1:0] buf_ien,
    input  logic [NUM_BUF-1:0] buf_is_tx,
    input  logic [LVL_W-1:0]   fifo_level,
    input  logic               fifo_ovr_pulse,
    input  logic               buf0_locked,
    input  logic [ERR_W-1:0]   chi_err,
    input  logic               host_flag_wr,
    input  logic               host_en_wr,
    input  logic [4:0]         host_wdata,
    output logic [4:0]         irq_flags,
    output logic [4:0]         irq_en,
    output logic               irq
);
    logic     rx_buf_any, tx_buf_any;
    logic     fne, ovr, ovr_clr;
    src_vec_t flags;

    msg_buf_summary #(.NUM_BUF(NUM_BUF)) u_buf (
        .buf_flag (buf_flag),
        .buf_ien  (buf_ien),
        .buf_is_tx(buf_is_tx),
        .rx_any   (rx_buf_any),
        .tx_any   (tx_buf_any)
    );

    // Only the overrun bit responds to a host flag write (write 1 to clear)
    assign ovr_clr = host_flag_wr & host_wdata[SRC_OVR];

    msg_fifo_status #(.LVL_W(LVL_W)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_level (fifo_level),
        .buf0_locked(buf0_locked),
        .ovr_pulse  (fifo_ovr_pulse),
        .ovr_clr    (ovr_clr),
        .fne        (fne),
        .ovr        (ovr)
    );

    always_comb begin
        flags          = '0;
        flags[SRC_RX]  = rx_buf_any | (fifo_level != '0);
        flags[SRC_TX]  = tx_buf_any;
        flags[SRC_ERR] = |chi_err;
        flags[SRC_FNE] = fne;
        flags[SRC_OVR] = ovr;
    end

    msg_irq_ctrl u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_wr   (host_en_wr),
        .en_wdata(host_wdata),
        .flags   (flags),
        .en      (irq_en),
        .irq     (irq)
    );

    assign irq_flags = flags;
endmodule

// File: rtl/msg_irq_chk.sv
module msg_irq_chk #(
    parameter int LVL_W = 4,
    parameter int ERR_W = 4,
    parameter int NUM_BUF = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_BUF-1:0] buf_ien,
    input logic [NUM_BUF-1:0] buf_is_tx,
    input logic [LVL_W-1:0]   fifo_level,
    input logic               fifo_ovr_pulse,
    input logic               buf0_locked,
    input logic [ERR_W-1:0]   chi_err,
    input logic               host_flag_wr,
    input logic [4:0]         host_wdata,
    input logic [4:0]         irq_flags,
    input logic [4:0]         irq_en,
    input logic               irq
);
    assert_tx_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((buf_ien & buf_is_tx) == '0) |-> !irq_flags[1]);

    assert_err_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (chi_err != '0) |-> irq_flags[2]);

    assert_fne_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_level != '0) |=> irq_flags[3]);

    assert_fne_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flags[3] && buf0_locked) |=> irq_flags[3]);

    assert_ovr_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_ovr_pulse |=> irq_flags[4]);

    assert_ovr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flags[4] && !(host_flag_wr && host_wdata[4])) |=> irq_flags[4]);

    assert_irq_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_flags & irq_en) != '0) |=> irq);

    assert_irq_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_flags & irq_en) == '0) |=> !irq);
endmodule

bind msg_irq_aggregator msg_irq_chk #(
    .LVL_W(LVL_W), .ERR_W(ERR_W), .NUM_BUF(NUM_BUF)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .buf_ien       (buf_ien),
    .buf_is_tx     (buf_is_tx),
    .fifo_level    (fifo_level),
    .fifo_ovr_pulse(fifo_ovr_pulse),
    .buf0_locked   (buf0_locked),
    .chi_err       (chi_err),
    .host_flag_wr  (host_flag_wr),
    .host_wdata    (host_wdata),
    .irq_flags     (irq_flags),
    .irq_en        (irq_en),
    .irq           (irq)
);

// File: tb/tb_msg_irq_aggregator.sv
`timescale 1ns/1ps
module tb_msg_irq_aggregator;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [15:0] buf_flag, buf_ien, buf_is_tx;
    logic [3:0]  fifo_level;
    logic        fifo_ovr_pulse, buf0_locked;
    logic [3:0]  chi_err;
    logic        host_flag_wr, host_en_wr;
    logic [4:0]  host_wdata;
    logic [4:0]  irq_flags, irq_en;
    logic        irq;

    always #2.5 clk = ~clk;

    msg_irq_aggregator dut (
        .clk(clk), .rst_n(rst_n), .buf_flag(buf_flag), .buf_ien(buf_ien),
        .buf_is_tx(buf_is_tx), .fifo_level(fifo_level),
        .fifo_ovr_pulse(fifo_ovr_pulse), .buf0_locked(buf0_locked),
        .chi_err(chi_err), .host_flag_wr(host_flag_wr), .host_en_wr(host_en_wr),
        .host_wdata(host_wdata), .irq_flags(irq_flags), .irq_en(irq_en), .irq(irq)
    );

    typedef struct {
        int         due;
        logic [4:0] fmask;
        logic [4:0] fval;
        logic       chk_irq;
        logic       irq_v;
        logic       chk_en;
        logic [4:0] en_v;
        string      req;
    } exp_t;

    exp_t queue_exp[$];
    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    bit   done = 0;

    always @(posedge clk) cyc <= cyc + 1;

    // Monitor: compares every expectation due in this cycle at the falling edge
    always @(negedge clk) begin
        while (queue_exp.size() > 0 && queue_exp[0].due <= cyc) begin
            exp_t it;
            logic bad;
            it  = queue_exp.pop_front();
            bad = (((irq_flags ^ it.fval) & it.fmask) != '0)
                | (it.chk_irq && irq !== it.irq_v)
                | (it.chk_en && irq_en !== it.en_v);
            checks++;
            if (bad) begin
                errors++;
                $display("FAIL %s: flags=%b irq=%b en=%b expected flags=%b (mask %b) irq=%b en=%b",
                         it.req, irq_flags, irq, irq_en, it.fval, it.fmask,
                         it.irq_v, it.en_v);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_st(input logic [4:0] fmask, input logic [4:0] fval,
                             input logic ci, input logic iv,
                             input logic ce, input logic [4:0] ev,
                             input string req);
        exp_t it;
        it.due = cyc; it.fmask = fmask; it.fval = fval;
        it.chk_irq = ci; it.irq_v = iv; it.chk_en = ce; it.en_v = ev;
        it.req = req;
        queue_exp.push_back(it);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not complete, expected completion");
            finish_run();
        end
    end

    initial begin
        rst_n = 1'b0; buf_flag = '0; buf_ien = '0; buf_is_tx = 16'hFF00;
        fifo_level = '0; fifo_ovr_pulse = 0; buf0_locked = 0; chi_err = '0;
        host_flag_wr = 0; host_en_wr = 0; host_wdata = '0;
        repeat (3) step();
        rst_n = 1'b1;
        // R9: reset state
        expect_st(5'h1F, 5'h00, 1, 0, 1, 5'h00, "R9 reset state");
        step();

        // R1: receive buffer 3, enable gates it
        buf_flag[3] = 1;
        expect_st(5'b00001, 5'b00000, 0, 0, 0, 0, "R1 disabled rx buffer");
        step();
        buf_ien[3] = 1;
        expect_st(5'b00011, 5'b00001, 0, 0, 0, 0, "R1 enabled rx buffer");
        step();
        // R2: transmit buffer 9 flagged but disabled, then enabled
        buf_flag[9] = 1;
        expect_st(5'b00010, 5'b00000, 0, 0, 0, 0, "R2 disabled tx buffer");
        step();
        buf_ien[9] = 1;
        expect_st(5'b00011, 5'b00011, 0, 0, 0, 0, "R2 enabled tx buffer empty");
        step();
        buf_flag[3] = 0; buf_flag[9] = 0;
        expect_st(5'b00011, 5'b00000, 0, 0, 0, 0, "R1 R2 all flags cleared");
        step();

        // R3
        chi_err = 4'b0100;
        expect_st(5'b00100, 5'b00100, 0, 0, 0, 0, "R3 error bit set");
        step();
        chi_err = '0;
        expect_st(5'b00100, 5'b00000, 0, 0, 0, 0, "R3 error bits clear");
        step();

        // R4 with R1 FIFO path
        fifo_level = 4'd2;
        expect_st(5'b01001, 5'b00001, 0, 0, 0, 0, "R1 R4 fifo fills, fne not yet");
        step();
        expect_st(5'b01000, 5'b01000, 0, 0, 0, 0, "R4 fne set after edge");
        buf0_locked = 1; fifo_level = '0;
        step();
        expect_st(5'b01001, 5'b01000, 0, 0, 0, 0, "R4 fne held while locked");
        step();
        expect_st(5'b01000, 5'b01000, 0, 0, 0, 0, "R4 fne still held");
        buf0_locked = 0;
        step();
        expect_st(5'b01000, 5'b00000, 0, 0, 0, 0, "R4 fne clears when unlocked");
        step();

        // R5
        fifo_ovr_pulse = 1;
        step();
        fifo_ovr_pulse = 0;
        expect_st(5'b10000, 5'b10000, 0, 0, 0, 0, "R5 overrun set");
        step(); step();
        expect_st(5'b10000, 5'b10000, 0, 0, 0, 0, "R5 overrun held");
        host_flag_wr = 1; host_wdata = 5'b01111;
        buf_flag[3] = 1; fifo_level = 4'd1;
        step();
        // R6: write of 1s to bits 0..3 changes nothing; overrun untouched too
        expect_st(5'b11111, 5'b11001, 0, 0, 0, 0, "R6 host write ignored");
        host_flag_wr = 1; host_wdata = 5'b10000; fifo_ovr_pulse = 1;
        step();
        expect_st(5'b10000, 5'b10000, 0, 0, 0, 0, "R5 pulse beats clear");
        fifo_ovr_pulse = 0;
        step();
        host_flag_wr = 0;
        expect_st(5'b10000, 5'b00000, 0, 0, 0, 0, "R5 host clear");
        step();

        // R7 / R8: enable receive flag only (rx live = 1 via buffer 3)
        host_en_wr = 1; host_wdata = 5'b00001;
        step();
        host_en_wr = 0; host_wdata = '0;
        expect_st(5'b00001, 5'b00001, 1, 0, 1, 5'b00001, "R7 enable loaded, R8 irq not yet");
        step();
        expect_st(5'b00000, 5'b00000, 1, 1, 1, 5'b00001, "R8 irq raised");
        buf_flag[3] = 0; fifo_level = '0;
        expect_st(5'b00001, 5'b00000, 1, 1, 0, 0, "R8 irq still high same cycle");
        step();
        expect_st(5'b00000, 5'b00000, 1, 0, 1, 5'b00001, "R8 irq dropped");
        step();

        // R8 via overrun with a different enable
        host_en_wr = 1; host_wdata = 5'b10000;
        step();
        host_en_wr = 0; fifo_ovr_pulse = 1;
        step();
        fifo_ovr_pulse = 0;
        expect_st(5'b10000, 5'b10000, 1, 0, 1, 5'b10000, "R8 ovr pending, irq due next");
        step();
        expect_st(5'b10000, 5'b10000, 1, 1, 0, 0, "R8 irq from overrun");
        step();

        // R9: reset mid-run
        rst_n = 0;
        step();
        rst_n = 1;
        expect_st(5'h1F, 5'h00, 1, 0, 1, 5'h00, "R9 reset clears state");
        step(); step();

        if (queue_exp.size() != 0) begin
            errors++;
            checks++;
            $display("FAIL scoreboard: %0d items left, expected 0", queue_exp.size());
        end
        done = 1;
        finish_run();
    end
endmodule